// File: doc/BRIEF.md
# Event-Select Performance Counter Unit

This unit keeps four 32-bit event counters for a processor core. Each cycle the core reports three quantities: how many processor cycles elapsed, how many loads and stores completed, and how many floating-point instructions completed. Each counter has a 6-bit event selector held in one of two 32-bit monitor control registers. The selector decides which of the three quantities, if any, is added to that counter. Additions wrap modulo 2^32.

Software reaches the counters and the two control registers through a small register port. Writes are synchronous and reads are combinational. The unit raises a level interrupt request when an enabled counter has its top bit set. The request is held by a sticky pending bit, which an acknowledge input clears. A separate flag tells the core whether any monitoring is configured at all.

Top module: `perf_event_counters`

## Requirements
- R1: After reset, all four counters and both control registers read zero, and `intReq` and `monActive` are low.
- R2: Register addresses map as follows: 0 to 3 are counters 0 to 3, 4 is control register A and 5 is control register B. Reads are combinational. Addresses 6 and 7 read zero, and writes to them change no register.
- R3: Counter 0 takes its selector from control A bits [5:0] and counter 1 from control A bits [11:6]. Counter 2 takes its selector from control B bits [5:0] and counter 3 from control B bits [11:6]. Selector code 0 leaves a counter unchanged.
- R4: Selector code 1 adds `cycInc` to the counter at each clock edge, on every counter, with the sum wrapping modulo 2^32.
- R5: Selector code 11 adds `ldStInc` on counter 1 and adds `fpInc` on counter 2. On counters 0 and 3, code 11 leaves the counter unchanged, as does any code other than 0, 1 and 11 on any counter.
- R6: A register write to a counter in the same cycle as an increment loads the written value, and the increment is dropped.
- R7: The interrupt condition is true when counter 0 bit 31 is set and control A bit 15 is set. It is also true when any of counters 1 to 3 has bit 31 set and control A bit 14 is set. `intReq` goes high one cycle after the condition becomes true.
- R8: Once set, `intReq` stays high until `intAck` is pulsed while the condition is false. An acknowledge given while the condition still holds has no effect.
- R9: `monActive` is high exactly when either control register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycInc | input | INC_W | Processor cycles elapsed this cycle |
| ldStInc | input | INC_W | Loads and stores completed this cycle |
| fpInc | input | INC_W | Floating-point instructions completed this cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| intAck | input | 1 | Clears the pending interrupt |
| intReq | output | 1 | Performance-monitor interrupt request |
| monActive | output | 1 | High when either control register is nonzero |

## Verification
The three event inputs are driven with different values at once (3, 4 and 9). This shows which source feeds which counter, and that code 11 means a different event on counters 1 and 2 and nothing on counters 0 and 3. Cycle counting runs over several cycles and also across the 2^32 boundary, which separates a wrapping add from a saturating one. A counter write is placed during live counting to show that the write wins. The interrupt is driven first through the shared enable and then through the counter-0 enable, with each enable on alone. This shows that the two enables are not swapped, and that acknowledging while the condition holds differs from acknowledging after it clears.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int CTR_W       = 32;
  localparam int NUM_CTR     = 4;
  localparam int CTR_PER_CTL = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CYC  = 2'd1,
    SRC_LDST = 2'd2,
    SRC_FPU  = 2'd3
  } evtSrc_e;

  typedef struct packed {
    logic [NUM_CTR-1:0]    ctrWr;
    logic [CTR_W-1:0]      wrData;
    evtSrc_e [NUM_CTR-1:0] src;
  } ctlStrobe_t;

  // Maps a selector code to an event source for one counter index.
  function automatic evtSrc_e decodeSel(input int idx, input int code);
    evtSrc_e r;
    r = SRC_NONE;
    if (code == 1) r = SRC_CYC;
    else if (code == 11 && idx == 1) r = SRC_LDST;
    else if (code == 11 && idx == 2) r = SRC_FPU;
    return r;
  endfunction
endpackage

// File: rtl/perf_ctl.sv
module perf_ctl
  import perf_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int SEL_W         = 6,
  parameter int SEL_LO_LSB    = 0,
  parameter int SEL_HI_LSB    = 6,
  parameter int IE_OWN_BIT    = 15,
  parameter int IE_SHARED_BIT = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CTR_W-1:0]   regWrData,
  input  logic               intAck,
  input  logic [NUM_CTR-1:0] ctrMsb,
  output ctlStrobe_t         strobe,
  output logic [CTR_W-1:0]   ctlAQ,
  output logic [CTR_W-1:0]   ctlBQ,
  output logic               intReq,
  output logic               monActive
);
  localparam logic [ADDR_W-1:0] ADDR_CTLA = ADDR_W'(NUM_CTR);
  localparam logic [ADDR_W-1:0] ADDR_CTLB = ADDR_W'(NUM_CTR + 1);

  logic pendingQ;
  logic intCond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlAQ <= '0;
      ctlBQ <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CTLA) ctlAQ <= regWrData;
      if (regAddr == ADDR_CTLB) ctlBQ <= regWrData;
    end
  end

  assign strobe.wrData = regWrData;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
    localparam int REG_IDX = g / CTR_PER_CTL;
    localparam int LSB     = (g % CTR_PER_CTL == 0) ? SEL_LO_LSB : SEL_HI_LSB;
    logic [SEL_W-1:0] selField;
    if (REG_IDX == 0) begin : g_a
      assign selField = ctlAQ[LSB +: SEL_W];
    end else begin : g_b
      assign selField = ctlBQ[LSB +: SEL_W];
    end
    assign strobe.src[g]   = decodeSel(g, int'(selField));
    assign strobe.ctrWr[g] = regWrEn && (regAddr == ADDR_W'(g));
  end

  assign intCond = (ctrMsb[0] & ctlAQ[IE_OWN_BIT]) |
                   ((|ctrMsb[NUM_CTR-1:1]) & ctlAQ[IE_SHARED_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= intCond | (pendingQ & ~intAck);
  end

  assign intReq    = pendingQ;
  assign monActive = (|ctlAQ) | (|ctlBQ);

  AST_INT_FOLLOWS_COND: assert property (@(posedge clk) disable iff (!rstN)
    intCond |=> intReq); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intCond) |=> !intReq); // R8
  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq); // R8
  AST_CTLA_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTLA) |=> ctlAQ == $past(regWrData)); // R2
endmodule

// File: rtl/perf_dp.sv
module perf_dp
  import perf_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic [INC_W-1:0]               cycInc,
  input  logic [INC_W-1:0]               ldStInc,
  input  logic [INC_W-1:0]               fpInc,
  output logic [NUM_CTR-1:0][CTR_W-1:0]  ctrQ
);
  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic [CTR_W-1:0] addend;

    always_comb begin
      unique case (strobe.src[g])
        SRC_CYC:  addend = CTR_W'(cycInc);
        SRC_LDST: addend = CTR_W'(ldStInc);
        SRC_FPU:  addend = CTR_W'(fpInc);
        default:  addend = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)                ctrQ[g] <= '0;
      else if (strobe.ctrWr[g]) ctrQ[g] <= strobe.wrData;
      else                      ctrQ[g] <= ctrQ[g] + addend;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.ctrWr[g] |=> ctrQ[g] == $past(strobe.wrData)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.ctrWr[g] && strobe.src[g] == SRC_NONE) |=> $stable(ctrQ[g])); // R3
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.ctrWr[g] && strobe.src[g] == SRC_CYC)
        |=> ctrQ[g] == $past(ctrQ[g]) + CTR_W'($past(cycInc))); // R4
  end
endmodule

// File: rtl/perf_event_counters.sv
module perf_event_counters
  import perf_pkg::*;
#(
  parameter int INC_W         = 8,
  parameter int ADDR_W        = 3,
  parameter int SEL_W         = 6,
  parameter int SEL_LO_LSB    = 0,
  parameter int SEL_HI_LSB    = 6,
  parameter int IE_OWN_BIT    = 15,
  parameter int IE_SHARED_BIT = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INC_W-1:0]  cycInc,
  input  logic [INC_W-1:0]  ldStInc,
  input  logic [INC_W-1:0]  fpInc,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              intAck,
  output logic              intReq,
  output logic              monActive
);
  ctlStrobe_t                   strobe;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctrQ;
  logic [NUM_CTR-1:0]            ctrMsb;
  logic [CTR_W-1:0]              ctlAQ;
  logic [CTR_W-1:0]              ctlBQ;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_msb
    assign ctrMsb[g] = ctrQ[g][CTR_W-1];
  end

  perf_ctl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_LO_LSB(SEL_LO_LSB), .SEL_HI_LSB(SEL_HI_LSB),
    .IE_OWN_BIT(IE_OWN_BIT), .IE_SHARED_BIT(IE_SHARED_BIT)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .intAck(intAck), .ctrMsb(ctrMsb), .strobe(strobe), .ctlAQ(ctlAQ), .ctlBQ(ctlBQ),
    .intReq(intReq), .monActive(monActive)
  );

  perf_dp #(.INC_W(INC_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cycInc(cycInc), .ldStInc(ldStInc),
    .fpInc(fpInc), .ctrQ(ctrQ)
  );

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (regAddr == ADDR_W'(i)) regRdData = ctrQ[i];
    if (regAddr == ADDR_W'(NUM_CTR))     regRdData = ctlAQ;
    if (regAddr == ADDR_W'(NUM_CTR + 1)) regRdData = ctlBQ;
  end
endmodule

// File: tb/perf_event_counters_tb.sv
`timescale 1ns/1ps
module perf_event_counters_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cycInc = '0, ldStInc = '0, fpInc = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        intAck = 1'b0;
  logic        intReq, monActive;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  perf_event_counters dut_i (
    .clk(clk), .rstN(rstN), .cycInc(cycInc), .ldStInc(ldStInc), .fpInc(fpInc),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .intAck(intAck), .intReq(intReq), .monActive(monActive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic clearAll();
    wrReg(3'd4, 32'h0); wrReg(3'd5, 32'h0);
    for (int i = 0; i < 4; i++) wrReg(3'(i), 32'h0);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      rdReg(3'(i), v);
      check("R1 reg zero", v, 32'h0);
    end
    check("R1 intReq", 32'(intReq), 32'h0);
    check("R1 monActive", 32'(monActive), 32'h0);
  endtask

  task automatic testMap();
    logic [31:0] v;
    wrReg(3'd0, 32'h1111_0001); wrReg(3'd1, 32'h2222_0002);
    wrReg(3'd2, 32'h3333_0003); wrReg(3'd3, 32'h4444_0004);
    wrReg(3'd4, 32'h0000_3000); wrReg(3'd5, 32'hABC0_0000);
    rdReg(3'd0, v); check("R2 ctr0", v, 32'h1111_0001);
    rdReg(3'd1, v); check("R2 ctr1", v, 32'h2222_0002);
    rdReg(3'd2, v); check("R2 ctr2", v, 32'h3333_0003);
    rdReg(3'd3, v); check("R2 ctr3", v, 32'h4444_0004);
    rdReg(3'd4, v); check("R2 ctlA", v, 32'h0000_3000);
    rdReg(3'd5, v); check("R2 ctlB", v, 32'hABC0_0000);
    check("R9 active", 32'(monActive), 32'h1);
    wrReg(3'd6, 32'hFFFF_FFFF);
    rdReg(3'd6, v); check("R2 addr6 zero", v, 32'h0);
    rdReg(3'd4, v); check("R2 ctlA untouched", v, 32'h0000_3000);
    rdReg(3'd0, v); check("R2 ctr0 untouched", v, 32'h1111_0001);
  endtask

  task automatic testCodeZero();
    logic [31:0] v;
    @(negedge clk); cycInc = 8'd5; ldStInc = 8'd5; fpInc = 8'd5;
    repeat (3) @(negedge clk);
    cycInc = '0; ldStInc = '0; fpInc = '0;
    rdReg(3'd0, v); check("R3 code0 ctr0", v, 32'h1111_0001);
    rdReg(3'd3, v); check("R3 code0 ctr3", v, 32'h4444_0004);
    wrReg(3'd4, 32'h0); wrReg(3'd5, 32'h0);
    check("R9 idle", 32'(monActive), 32'h0);
    wrReg(3'd5, 32'h0010_0000);
    check("R9 ctlB nonzero", 32'(monActive), 32'h1);
  endtask

  task automatic testCycles();
    logic [31:0] v;
    clearAll();
    wrReg(3'd4, 32'h41); wrReg(3'd5, 32'h41);
    @(negedge clk); cycInc = 8'd7;
    repeat (4) @(negedge clk);
    cycInc = '0;
    for (int i = 0; i < 4; i++) begin
      rdReg(3'(i), v); check("R4 cycle count", v, 32'd28);
    end
    wrReg(3'd4, 32'h1);
    wrReg(3'd0, 32'hFFFF_FFFE);
    @(negedge clk); cycInc = 8'd5;
    @(negedge clk); cycInc = '0;
    rdReg(3'd0, v); check("R4 wrap", v, 32'd3);
  endtask

  task automatic testSources();
    logic [31:0] v;
    clearAll();
    wrReg(3'd4, 32'h2CB); wrReg(3'd5, 32'h2CB);
    @(negedge clk); cycInc = 8'd3; ldStInc = 8'd4; fpInc = 8'd9;
    repeat (2) @(negedge clk);
    cycInc = '0; ldStInc = '0; fpInc = '0;
    rdReg(3'd0, v); check("R5 ctr0 code11 none", v, 32'd0);
    rdReg(3'd1, v); check("R5 ctr1 loads/stores", v, 32'd8);
    rdReg(3'd2, v); check("R5 ctr2 fp", v, 32'd18);
    rdReg(3'd3, v); check("R5 ctr3 code11 none", v, 32'd0);
    wrReg(3'd4, 32'h142);
    @(negedge clk); cycInc = 8'd3; ldStInc = 8'd4; fpInc = 8'd9;
    @(negedge clk); cycInc = '0; ldStInc = '0; fpInc = '0;
    rdReg(3'd0, v); check("R5 ctr0 code2 none", v, 32'd0);
    rdReg(3'd1, v); check("R5 ctr1 code5 none", v, 32'd8);
  endtask

  task automatic testWritePriority();
    logic [31:0] v;
    clearAll();
    wrReg(3'd4, 32'h1);
    @(negedge clk); cycInc = 8'd10;
    wrReg(3'd0, 32'd100);
    rdReg(3'd0, v); check("R6 write wins", v, 32'd100);
    @(negedge clk); cycInc = '0;
    rdReg(3'd0, v); check("R6 counts after write", v, 32'd110);
  endtask

  task automatic testInterrupt();
    clearAll();
    check("R8 cleared", 32'(intReq), 32'h0);
    wrReg(3'd4, 32'h0000_4000);
    wrReg(3'd0, 32'h8000_0000);
    repeat (2) @(negedge clk);
    check("R7 ctr0 needs own enable", 32'(intReq), 32'h0);
    wrReg(3'd2, 32'h8000_0000);
    check("R7 one cycle lag", 32'(intReq), 32'h0);
    @(negedge clk);
    check("R7 shared enable", 32'(intReq), 32'h1);
    intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    @(negedge clk);
    check("R8 ack while cond holds", 32'(intReq), 32'h1);
    wrReg(3'd2, 32'h0);
    repeat (2) @(negedge clk);
    check("R8 sticky", 32'(intReq), 32'h1);
    intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    check("R8 ack clears", 32'(intReq), 32'h0);
    wrReg(3'd4, 32'h0000_8000);
    @(negedge clk);
    check("R7 own enable", 32'(intReq), 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testCodeZero();
    testCycles();
    testSources();
    testWritePriority();
    testInterrupt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule